// File: doc/BRIEF.md
# PTP System Time Counter

This block holds a 64-bit time of day for a precision time protocol endpoint. The upper 32 bits count whole seconds and the lower 32 bits count sub-seconds in nanosecond units, rolling over into the seconds word at one billion. Each cycle the time either moves forward by a programmable sub-second step or stays where it is. In fine mode a 32-bit phase accumulator adds a programmable addend every cycle. Each carry out of that accumulator allows one step. Software trims the addend to cancel reference-clock drift. In coarse mode the step is applied on every cycle.

Software can also correct the time. An init strobe loads both words outright, and an update strobe adds a signed offset to the running time, carrying or borrowing across the seconds boundary. Either command is held in a one-entry staging register and applied on the following cycle, and a busy flag is high while it waits. Frame-event pulses from the transmit and receive paths capture the current time into a one-entry snapshot slot. The slot drains over a valid/ready interface: its data stay stable while valid is high and ready is low. An event is accepted when the slot is empty or is being drained in the same cycle, and is dropped otherwise.

Top module: `ptp_clock_core`

## Requirements
- R1: While rst_n is low, time_sec and time_sub read 0, busy and snap_valid read 0, and the phase accumulator is cleared.
- R2: With fine_mode=1, the addend is added to a 32-bit accumulator on every cycle, modulo 2^32, and the residue is kept. A carry out at one clock edge advances time_sub by ss_inc at the next edge.
- R3: With fine_mode=0, time_sub advances by ss_inc on every clock edge that applies no command, and the accumulator holds its value.
- R4: When an advance makes time_sub reach or pass 1,000,000,000, time_sub becomes the sum minus 1,000,000,000 and time_sec increments by one, modulo 2^32.
- R5: A one-cycle init_stb captures upd_sec and upd_sub at that edge. At the next edge the time becomes exactly those values, and any step due in that cycle is discarded.
- R6: A one-cycle update_stb with upd_neg=0 adds upd_sec and upd_sub to the time at the next edge, carrying into seconds when the sub-second sum reaches 1,000,000,000.
- R7: An update_stb with upd_neg=1 subtracts the values instead. A negative sub-second result borrows one second and adds 1,000,000,000, and the seconds word wraps modulo 2^32.
- R8: When init_stb and update_stb are high in the same cycle, only the init is staged.
- R9: busy is high for exactly the one cycle between capture and application of a command. init_stb and update_stb are ignored while busy is high.
- R10: A new addend value is used from the first edge at which it is presented, and the accumulator is not cleared by the change.
- R11: When evt_stb is high at an edge and is accepted, snap_sec and snap_sub take the time value that was on time_sec and time_sub just before that edge, and snap_valid rises.
- R12: While snap_valid=1 and snap_ready=0, the snapshot data are stable and a new evt_stb is dropped. With snap_ready=1 the slot empties, or refills at once if evt_stb is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fine_mode | input | 1 | 1 = accumulator-gated steps, 0 = step every cycle |
| addend | input | 32 | Value added to the phase accumulator each cycle |
| ss_inc | input | 32 | Sub-second step applied per advance |
| upd_sec | input | 32 | Seconds value for init or offset |
| upd_sub | input | 32 | Sub-second value for init or offset |
| upd_neg | input | 1 | 1 = offset is subtracted, 0 = added |
| init_stb | input | 1 | Load time from the update values |
| update_stb | input | 1 | Apply signed offset from the update values |
| evt_stb | input | 1 | Frame event, captures the current time |
| snap_ready | input | 1 | Consumer accepts the snapshot |
| time_sec | output | 32 | Current seconds |
| time_sub | output | 32 | Current sub-seconds |
| busy | output | 1 | A staged command is waiting to be applied |
| snap_valid | output | 1 | Snapshot slot holds data |
| snap_sec | output | 32 | Captured seconds |
| snap_sub | output | 32 | Captured sub-seconds |

## Verification
The assertions assume that upd_sub and ss_inc stay below one billion whenever they are used, and that any loaded sub-second value does too. Under those conditions time_sub never leaves its decimal range, and a single step moves the seconds word by at most one. The stimulus therefore draws every sub-second operand modulo one billion. It issues strobes as single-cycle pulses and varies snap_ready freely, so the back-pressure rules are exercised both when events are accepted and when they are dropped.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam int SEC_W = 32;
  localparam int SUB_W = 32;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [SUB_W-1:0] sub;
  } ptp_time_t;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_SHIFT = 2'd2
  } ptp_cmd_e;

  typedef struct packed {
    ptp_cmd_e  kind;
    logic      neg;
    ptp_time_t val;
  } ptp_pend_t;
endpackage

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] addend,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             carry;
  logic             tick_q;

  assign {carry, sum} = {1'b0, acc_q} + {1'b0, addend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (en) begin
      acc_q  <= sum;
      tick_q <= carry;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

  // R2: a step pulse only follows a cycle in which the accumulator ran
  a_r2_tick_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(en));
  // R3: accumulator frozen while coarse mode is selected
  a_r3_acc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/ptp_cmd_stage.sv
module ptp_cmd_stage
  import ptp_time_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_stb,
  input  logic             update_stb,
  input  logic             upd_neg,
  input  logic [SEC_W-1:0] upd_sec,
  input  logic [SUB_W-1:0] upd_sub,
  output ptp_pend_t        pend,
  output logic             busy
);
  ptp_pend_t pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_q.kind != CMD_IDLE) begin
      pend_q.kind <= CMD_IDLE;
    end else if (init_stb) begin
      pend_q.kind    <= CMD_LOAD;
      pend_q.neg     <= 1'b0;
      pend_q.val.sec <= upd_sec;
      pend_q.val.sub <= upd_sub;
    end else if (update_stb) begin
      pend_q.kind    <= CMD_SHIFT;
      pend_q.neg     <= upd_neg;
      pend_q.val.sec <= upd_sec;
      pend_q.val.sub <= upd_sub;
    end
  end

  assign pend = pend_q;
  assign busy = (pend_q.kind != CMD_IDLE);

  // R9: a staged command waits exactly one cycle
  a_r9_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R8: init wins when both strobes arrive together
  a_r8_init_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (init_stb && !busy) |=> (pend_q.kind == CMD_LOAD));
  // R9: strobes while busy stage nothing
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (pend_q.kind == CMD_IDLE));
endmodule

// File: rtl/ptp_time_reg.sv
module ptp_time_reg
  import ptp_time_pkg::*;
#(
  parameter int unsigned ROLLOVER = 32'd1_000_000_000,
  parameter bit          BIN_ROLL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [SUB_W-1:0] step,
  input  ptp_pend_t        pend,
  output ptp_time_t        now
);
  localparam logic [SUB_W:0]   ROLL_X  = BIN_ROLL ? (SUB_W+1)'(1) << SUB_W
                                                  : {1'b0, SUB_W'(ROLLOVER)};
  localparam logic [SUB_W-1:0] ROLL_LO = SUB_W'(ROLL_X);

  function automatic ptp_time_t t_add(ptp_time_t t, logic [SEC_W-1:0] ds,
                                      logic [SUB_W-1:0] dn);
    logic [SUB_W:0] s;
    logic           w;
    s = {1'b0, t.sub} + {1'b0, dn};
    w = (s >= ROLL_X);
    t_add.sub = w ? SUB_W'(s - ROLL_X) : s[SUB_W-1:0];
    t_add.sec = t.sec + ds + SEC_W'(w);
  endfunction

  function automatic ptp_time_t t_sub(ptp_time_t t, logic [SEC_W-1:0] ds,
                                      logic [SUB_W-1:0] dn);
    logic [SUB_W-1:0] d;
    logic             b;
    b = (t.sub < dn);
    d = t.sub - dn;
    t_sub.sub = b ? d + ROLL_LO : d;
    t_sub.sec = t.sec - ds - SEC_W'(b);
  endfunction

  ptp_time_t now_q;
  ptp_time_t nxt;

  always_comb begin
    nxt = now_q;
    unique case (pend.kind)
      CMD_LOAD:  nxt = pend.val;
      CMD_SHIFT: nxt = pend.neg ? t_sub(now_q, pend.val.sec, pend.val.sub)
                                : t_add(now_q, pend.val.sec, pend.val.sub);
      default:   if (adv) nxt = t_add(now_q, '0, step);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= nxt;
  end

  assign now = now_q;

  // R4: sub-second word stays inside its rollover range
  a_r4_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, now_q.sub} < ROLL_X);
  // R4: a step moves seconds by at most one
  a_r4_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pend.kind == CMD_IDLE) |=>
      (now_q.sec == $past(now_q.sec)) || (now_q.sec == $past(now_q.sec) + 1'b1));
  // R3: an enabled non-zero step always changes the sub-second word
  a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (pend.kind == CMD_IDLE && adv && step != '0) |=> (now_q.sub != $past(now_q.sub)));
endmodule

// File: rtl/ptp_snap_slot.sv
module ptp_snap_slot
  import ptp_time_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      evt,
  input  ptp_time_t now,
  input  logic      ready,
  output logic      valid,
  output ptp_time_t data
);
  logic      valid_q;
  ptp_time_t data_q;
  logic      take;

  assign take = evt && (!valid_q || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      data_q  <= now;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign data  = data_q;

  // R12: held snapshot does not move under back-pressure
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(data_q)));
  // R11: an event always leaves the slot full
  a_r11_fill: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> valid_q);
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core
  import ptp_time_pkg::*;
#(
  parameter int          ACC_W    = 32,
  parameter int unsigned ROLLOVER = 32'd1_000_000_000,
  parameter bit          BIN_ROLL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine_mode,
  input  logic [ACC_W-1:0] addend,
  input  logic [SUB_W-1:0] ss_inc,
  input  logic [SEC_W-1:0] upd_sec,
  input  logic [SUB_W-1:0] upd_sub,
  input  logic             upd_neg,
  input  logic             init_stb,
  input  logic             update_stb,
  input  logic             evt_stb,
  input  logic             snap_ready,
  output logic [SEC_W-1:0] time_sec,
  output logic [SUB_W-1:0] time_sub,
  output logic             busy,
  output logic             snap_valid,
  output logic [SEC_W-1:0] snap_sec,
  output logic [SUB_W-1:0] snap_sub
);
  logic      tick;
  logic      adv;
  ptp_pend_t pend;
  ptp_time_t now;
  ptp_time_t snap;

  ptp_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(fine_mode), .addend(addend), .tick(tick)
  );

  ptp_cmd_stage u_cmd (
    .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .update_stb(update_stb),
    .upd_neg(upd_neg), .upd_sec(upd_sec), .upd_sub(upd_sub),
    .pend(pend), .busy(busy)
  );

  assign adv = fine_mode ? tick : 1'b1;

  ptp_time_reg #(.ROLLOVER(ROLLOVER), .BIN_ROLL(BIN_ROLL)) u_time (
    .clk(clk), .rst_n(rst_n), .adv(adv), .step(ss_inc), .pend(pend), .now(now)
  );

  ptp_snap_slot u_snap (
    .clk(clk), .rst_n(rst_n), .evt(evt_stb), .now(now), .ready(snap_ready),
    .valid(snap_valid), .data(snap)
  );

  assign time_sec = now.sec;
  assign time_sub = now.sub;
  assign snap_sec = snap.sec;
  assign snap_sub = snap.sub;
endmodule

// File: tb/sim_ptp_clock_core.sv
module sim_ptp_clock_core;
  localparam longint ROLL = 64'd1_000_000_000;
  localparam longint M32  = 64'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fine_mode = 1'b0;
  logic [31:0] addend = '0, ss_inc = '0, upd_sec = '0, upd_sub = '0;
  logic        upd_neg = 1'b0, init_stb = 1'b0, update_stb = 1'b0;
  logic        evt_stb = 1'b0, snap_ready = 1'b0;
  logic [31:0] time_sec, time_sub, snap_sec, snap_sub;
  logic        busy, snap_valid;

  int    n_chk = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ptp_clock_core u0 (.*);

  // behavioural reference model
  longint m_acc, m_sec, m_sub, m_psec, m_psub, m_ssec, m_ssub;
  int     m_kind;
  bit     m_tick, m_pneg, m_sv;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    longint nsec, nsub, a;
    if (!rst_n) begin
      m_acc = 0; m_sec = 0; m_sub = 0; m_kind = 0; m_tick = 0; m_sv = 0;
      m_ssec = 0; m_ssub = 0; m_psec = 0; m_psub = 0; m_pneg = 0;
    end else begin
      nsec = m_sec; nsub = m_sub;
      if (m_kind == 1) begin nsec = m_psec; nsub = m_psub; end
      else if (m_kind == 2) begin
        if (!m_pneg) begin
          nsub = m_sub + m_psub; nsec = m_sec + m_psec;
          if (nsub >= ROLL) begin nsub -= ROLL; nsec += 1; end
        end else begin
          nsub = m_sub - m_psub; nsec = m_sec - m_psec;
          if (nsub < 0) begin nsub += ROLL; nsec -= 1; end
        end
      end else if (fine_mode ? m_tick : 1'b1) begin
        nsub = m_sub + longint'(ss_inc);
        if (nsub >= ROLL) begin nsub -= ROLL; nsec += 1; end
      end
      nsec = nsec & M32;
      if (evt_stb && (!m_sv || snap_ready)) begin
        m_ssec = m_sec; m_ssub = m_sub; m_sv = 1;
      end else if (snap_ready) m_sv = 0;
      if (fine_mode) begin
        a = m_acc + longint'(addend);
        m_tick = (a > M32);
        m_acc = a & M32;
      end else m_tick = 0;
      if (m_kind != 0) m_kind = 0;
      else if (init_stb) begin
        m_kind = 1; m_psec = upd_sec; m_psub = upd_sub; m_pneg = 0;
      end else if (update_stb) begin
        m_kind = 2; m_psec = upd_sec; m_psub = upd_sub; m_pneg = upd_neg;
      end
      m_sec = nsec; m_sub = nsub;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "time_sec", time_sec, m_sec);
      chk(cur_req, "time_sub", time_sub, m_sub);
      chk(cur_req, "busy", busy, (m_kind != 0));
      chk(cur_req, "snap_valid", snap_valid, m_sv);
      if (m_sv) begin
        chk(cur_req, "snap_sec", snap_sec, m_ssec);
        chk(cur_req, "snap_sub", snap_sub, m_ssub);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(bit ini, bit upd, bit neg, longint s, longint n);
    @(negedge clk);
    init_stb = ini; update_stb = upd; upd_neg = neg;
    upd_sec = 32'(s); upd_sub = 32'(n);
    @(negedge clk);
    init_stb = 0; update_stb = 0;
  endtask

  task automatic chk_time(string req, longint s, longint n);
    chk(req, "time_sec", time_sec, s);
    chk(req, "time_sub", time_sub, n);
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1", "time_sec", time_sec, 0);
    chk("R1", "time_sub", time_sub, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "snap_valid", snap_valid, 0);
    rst_n = 1'b1;

    cur_req = "R3"; ss_inc = 32'd7; cyc(20);

    cur_req = "R5"; ss_inc = 32'd3;
    cmd(1, 0, 0, 10, 999_999_995);
    cyc(1); chk_time("R5", 10, 999_999_995);
    cur_req = "R4"; cyc(2); chk_time("R4", 11, 1);

    cur_req = "R2"; fine_mode = 1; addend = 32'h4000_0000; ss_inc = 32'd20; cyc(40);
    addend = 32'hFFFF_FFFF; cyc(20);
    cur_req = "R10"; addend = 32'h9000_0000; cyc(15); addend = 32'h0123_4567; cyc(40);

    fine_mode = 0; ss_inc = 0;
    cur_req = "R6";
    cmd(1, 0, 0, 100, 600_000_000); cyc(1);
    cmd(0, 1, 0, 2, 500_000_000); cyc(1); chk_time("R6", 103, 100_000_000);
    cur_req = "R7";
    cmd(0, 1, 1, 5, 200_000_000); cyc(1); chk_time("R7", 97, 900_000_000);
    cmd(1, 0, 0, 0, 0); cyc(1);
    cmd(0, 1, 1, 0, 1); cyc(1); chk_time("R7", 64'hFFFF_FFFF, 999_999_999);

    cur_req = "R9";
    cmd(1, 0, 0, 40, 123);
    chk("R9", "busy", busy, 1);
    update_stb = 1; upd_sec = 1; upd_sub = 1;
    @(negedge clk); update_stb = 0;
    chk("R9", "busy", busy, 0);
    chk_time("R9", 40, 123);
    cyc(2); chk_time("R9", 40, 123);

    cur_req = "R8";
    cmd(1, 1, 0, 7, 7); cyc(1); chk_time("R8", 7, 7);

    cur_req = "R11"; ss_inc = 32'd1000;
    @(negedge clk); evt_stb = 1; snap_ready = 0;
    @(negedge clk); evt_stb = 0;
    chk("R11", "snap_valid", snap_valid, 1);
    cur_req = "R12";
    cyc(2); evt_stb = 1; cyc(1); evt_stb = 0; cyc(2);
    chk("R12", "snap_valid", snap_valid, 1);
    snap_ready = 1; cyc(1);
    chk("R12", "snap_valid", snap_valid, 0);
    evt_stb = 1; cyc(3); evt_stb = 0; cyc(2);

    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 99) < 2) fine_mode = ~fine_mode;
      if ($urandom_range(0, 99) < 5) addend = $urandom;
      if ($urandom_range(0, 99) < 5) ss_inc = 32'($urandom % 32'd1_000_000_000);
      upd_sec = $urandom;
      upd_sub = 32'($urandom % 32'd1_000_000_000);
      upd_neg = $urandom_range(0, 1);
      init_stb = ($urandom_range(0, 99) < 3);
      update_stb = ($urandom_range(0, 99) < 6);
      evt_stb = ($urandom_range(0, 99) < 25);
      snap_ready = $urandom_range(0, 1);
    end
    @(negedge clk);
    init_stb = 0; update_stb = 0; evt_stb = 0;
    cyc(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule